// File: doc/BRIEF.md
# Two-Level Page Translation Walker

This block turns a 32-bit virtual address into a physical address. It walks a two-level page table whose root frame comes from a configuration input. Pages are 4 KB. For each request it reads one directory entry and then one leaf entry through a word-wide memory port. It merges the permission flags of both levels, keeping the most restrictive result, and checks them against the kind of access: read or write, user or supervisor. It then answers with either a physical address plus one cacheability attribute, or a fault code.

When an access succeeds and an entry has its accessed flag clear, the walker writes that entry back with the flag set. Only that one word is rewritten. A translation-disable input turns the block into an identity map that issues no memory traffic.

Requests and responses are valid/ready streams. A request is taken only when `req_ready` is high, and that happens only while no walk or response is pending. A response stays on `rsp_*` unchanged until `rsp_ready` accepts it. While the response waits, no new request is accepted.

The memory port is a request stream with `mem_ready` as back-pressure. Read data comes back on `mem_rvalid`, which cannot be stalled. At most one read is outstanding at a time. Configuration inputs are plain levels and must be held steady while a walk is in progress.

Top module: `pt_walker`

## Requirements
- R1: After reset `req_ready` is 1 and `rsp_valid` and `mem_valid` are 0. A request is accepted only when `req_valid` and `req_ready` are both high. `req_ready` stays low from acceptance until the response has been taken. While `rsp_ready` is low, `rsp_valid` and every `rsp_*` field hold their values.
- R2: The directory entry word is read from {`cfg_root`, va[31:22], 2'b00}. The leaf entry word is read from {dir[31:12], va[21:12], 2'b00}. A successful walk returns `rsp_paddr` = {leaf[31:12], va[11:0]}.
- R3: Entry flag bits are: bit0 present, bit1 writable, bit2 user, bit3 write-through, bit4 cache-disable, bit5 accessed, bit6 dirty (leaf only). A clear present bit at either level gives `rsp_fault`=1 with `rsp_fcode`=0. A non-present directory entry ends the walk after a single memory read.
- R4: A user access (`req_user`=1) faults with code 1 unless the user bit is set at both levels.
- R5: A write faults with code 2 unless the writable bit is set at both levels. This check applies to user writes, and to supervisor writes only when `cfg_wp`=1. With `cfg_wp`=0 a supervisor write ignores the writable bits.
- R6: A write to a leaf whose dirty bit is 0 faults with code 3.
- R7: Fault codes take priority in the order 0, 1, 2, 3: a lower code is reported whenever its condition holds. On any fault `rsp_paddr` and `rsp_attr` are 0.
- R8: After a fault-free walk, each level whose accessed bit is 0 gets one memory write of its own entry word with bit5 set and all other bits unchanged. The directory is written before the leaf. No write happens for a level whose bit is already set, and none happens after a fault.
- R9: Write-through and cache-disable are each the OR of both levels. `rsp_attr` is the cache-disable value when `cfg_pbm`=0 and the write-through value when `cfg_pbm`=1.
- R10: With `cfg_xlate_off`=1 the response carries `rsp_paddr` equal to the request address, with no fault and `rsp_attr`=0. It makes no memory access, and `rsp_valid` rises at the clock edge that accepts the request.
- R11: Assume a memory that accepts at once and returns read data in the cycle after acceptance. Then `rsp_valid` rises 5 clock edges after the accepting edge for a full walk, plus 1 edge for each accessed-bit write. A non-present directory entry gives 2 edges.
- R12: `mem_valid`, `mem_we`, `mem_addr` and `mem_wdata` hold steady until `mem_ready` accepts the request. No new memory request is raised while a read is awaiting `mem_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_xlate_off | input | 1 | Identity mapping, no walk |
| cfg_root | input | 20 | Frame number of the directory table |
| cfg_wp | input | 1 | Supervisor writes obey the writable bits |
| cfg_pbm | input | 1 | Attribute select: 0 cache-disable, 1 write-through |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block idle, request can be taken |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response accepted |
| rsp_paddr | output | 32 | Physical address, 0 on fault |
| rsp_fault | output | 1 | Translation failed |
| rsp_fcode | output | 2 | 0 not present, 1 privilege, 2 write-protect, 3 dirty |
| rsp_attr | output | 1 | Selected cacheability attribute |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Byte address of the entry word |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The hardest state to reach is an accessed-bit write that has to wait under memory back-pressure at the end of a walk. The walk must also have checked clean at both levels while the directory entry's accessed bit was still clear. A related case is a leaf-level fault that follows a directory entry with its accessed bit clear, where no write may appear at all. The bench builds page tables by hand so that directory entries start with the accessed bit clear and lead to leaves that pass or fail chosen checks. It then repeats some of those walks while a pseudo-random sequence drops `mem_ready` and `rsp_ready`. Memory contents are read back afterwards to confirm which words changed.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;
  // flag bit positions inside a table entry word
  localparam int unsigned F_P  = 0;
  localparam int unsigned F_W  = 1;
  localparam int unsigned F_U  = 2;
  localparam int unsigned F_WT = 3;
  localparam int unsigned F_CD = 4;
  localparam int unsigned F_A  = 5;
  localparam int unsigned F_D  = 6;
  localparam int unsigned FLAG_W     = F_D + 1;  // leaf flags
  localparam int unsigned DIR_FLAG_W = F_D;      // directory has no dirty flag

  typedef enum logic [1:0] {
    FLT_NOTPRES = 2'd0,
    FLT_PRIV    = 2'd1,
    FLT_WPROT   = 2'd2,
    FLT_DIRTY   = 2'd3
  } fault_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DIR_RQ, ST_DIR_WT, ST_LEAF_RQ, ST_LEAF_WT,
    ST_CHECK, ST_DIR_WB, ST_LEAF_WB, ST_RESP
  } walk_st_e;
endpackage

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
  parameter int unsigned AW        = 32,
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned IDX_BITS  = 10
) (
  input  logic [AW-PAGE_BITS-1:0] root_frame,
  input  logic [AW-PAGE_BITS-1:0] dir_frame,
  input  logic [AW-PAGE_BITS-1:0] leaf_frame,
  input  logic [AW-1:0]           va,
  output logic [AW-1:0]           dir_addr,
  output logic [AW-1:0]           pte_addr,
  output logic [AW-1:0]           pa
);
  localparam int unsigned EB     = PAGE_BITS - IDX_BITS;  // byte bits of one entry
  localparam int unsigned HI_LSB = PAGE_BITS + IDX_BITS;

  assign dir_addr = {root_frame, va[AW-1:HI_LSB], {EB{1'b0}}};
  assign pte_addr = {dir_frame, va[HI_LSB-1:PAGE_BITS], {EB{1'b0}}};
  assign pa       = {leaf_frame, va[PAGE_BITS-1:0]};
endmodule

// File: rtl/pt_perm_check.sv
module pt_perm_check
  import pt_walk_pkg::*;
(
  input  logic [DIR_FLAG_W-1:0] dir_f,
  input  logic [FLAG_W-1:0]     leaf_f,
  input  logic                  is_write,
  input  logic                  is_user,
  input  logic                  wp_en,
  input  logic                  attr_sel,
  output logic                  fault,
  output fault_e                code,
  output logic                  attr,
  output logic                  wb_dir,
  output logic                  wb_leaf
);
  logic u_ok, w_ok, cd_any, wt_any;

  always_comb begin
    // most restrictive merge of the two levels
    u_ok   = dir_f[F_U] & leaf_f[F_U];
    w_ok   = dir_f[F_W] & leaf_f[F_W];
    cd_any = dir_f[F_CD] | leaf_f[F_CD];
    wt_any = dir_f[F_WT] | leaf_f[F_WT];

    fault = 1'b1;
    code  = FLT_NOTPRES;
    if (!dir_f[F_P] || !leaf_f[F_P]) begin
      code = FLT_NOTPRES;
    end else if (is_user && !u_ok) begin
      code = FLT_PRIV;
    end else if (is_write && !w_ok && (is_user || wp_en)) begin
      code = FLT_WPROT;
    end else if (is_write && !leaf_f[F_D]) begin
      code = FLT_DIRTY;
    end else begin
      fault = 1'b0;
    end

    attr    = fault ? 1'b0 : (attr_sel ? wt_any : cd_any);
    wb_dir  = !fault && !dir_f[F_A];
    wb_leaf = !fault && !leaf_f[F_A];
  end
endmodule

// File: rtl/pt_walk_ctl.sv
module pt_walk_ctl
  import pt_walk_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned PAGE_BITS = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_xlate_off,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [AW-1:0]           req_vaddr,
  input  logic                    req_write,
  input  logic                    req_user,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [AW-1:0]           rsp_paddr,
  output logic                    rsp_fault,
  output logic [1:0]              rsp_fcode,
  output logic                    rsp_attr,
  output logic                    mem_valid,
  input  logic                    mem_ready,
  output logic                    mem_we,
  output logic [AW-1:0]           mem_addr,
  output logic [AW-1:0]           mem_wdata,
  input  logic                    mem_rvalid,
  input  logic [AW-1:0]           mem_rdata,
  input  logic [AW-1:0]           dir_addr,
  input  logic [AW-1:0]           pte_addr,
  input  logic [AW-1:0]           pa,
  input  logic                    chk_fault,
  input  fault_e                  chk_code,
  input  logic                    chk_attr,
  input  logic                    wb_dir,
  input  logic                    wb_leaf,
  output logic [AW-1:0]           va_q,
  output logic                    wr_q,
  output logic                    user_q,
  output logic [AW-PAGE_BITS-1:0] dir_frame,
  output logic [AW-PAGE_BITS-1:0] leaf_frame,
  output logic [DIR_FLAG_W-1:0]   dir_flags,
  output logic [FLAG_W-1:0]       leaf_flags
);
  localparam logic [AW-1:0] A_MASK = {{(AW-1){1'b0}}, 1'b1} << F_A;

  walk_st_e      state;
  logic [AW-1:0] va_r, dir_r, leaf_r, rsp_pa_r;
  logic          wr_r, user_r, rsp_valid_r, rsp_fault_r, rsp_attr_r;
  fault_e        rsp_code_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      va_r        <= '0;
      dir_r       <= '0;
      leaf_r      <= '0;
      wr_r        <= 1'b0;
      user_r      <= 1'b0;
      rsp_valid_r <= 1'b0;
      rsp_pa_r    <= '0;
      rsp_fault_r <= 1'b0;
      rsp_code_r  <= FLT_NOTPRES;
      rsp_attr_r  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          va_r   <= req_vaddr;
          wr_r   <= req_write;
          user_r <= req_user;
          if (cfg_xlate_off) begin
            rsp_valid_r <= 1'b1;
            rsp_pa_r    <= req_vaddr;
            rsp_fault_r <= 1'b0;
            rsp_code_r  <= FLT_NOTPRES;
            rsp_attr_r  <= 1'b0;
            state       <= ST_RESP;
          end else begin
            state <= ST_DIR_RQ;
          end
        end
        ST_DIR_RQ: if (mem_ready) state <= ST_DIR_WT;
        ST_DIR_WT: if (mem_rvalid) begin
          dir_r <= mem_rdata;
          if (!mem_rdata[F_P]) begin
            rsp_valid_r <= 1'b1;
            rsp_pa_r    <= '0;
            rsp_fault_r <= 1'b1;
            rsp_code_r  <= FLT_NOTPRES;
            rsp_attr_r  <= 1'b0;
            state       <= ST_RESP;
          end else begin
            state <= ST_LEAF_RQ;
          end
        end
        ST_LEAF_RQ: if (mem_ready) state <= ST_LEAF_WT;
        ST_LEAF_WT: if (mem_rvalid) begin
          leaf_r <= mem_rdata;
          state  <= ST_CHECK;
        end
        ST_CHECK: begin
          if (chk_fault) begin
            rsp_valid_r <= 1'b1;
            rsp_pa_r    <= '0;
            rsp_fault_r <= 1'b1;
            rsp_code_r  <= chk_code;
            rsp_attr_r  <= 1'b0;
            state       <= ST_RESP;
          end else if (wb_dir) begin
            state <= ST_DIR_WB;
          end else if (wb_leaf) begin
            state <= ST_LEAF_WB;
          end else begin
            rsp_valid_r <= 1'b1;
            rsp_pa_r    <= pa;
            rsp_fault_r <= 1'b0;
            rsp_code_r  <= FLT_NOTPRES;
            rsp_attr_r  <= chk_attr;
            state       <= ST_RESP;
          end
        end
        ST_DIR_WB: if (mem_ready) begin
          if (wb_leaf) begin
            state <= ST_LEAF_WB;
          end else begin
            rsp_valid_r <= 1'b1;
            rsp_pa_r    <= pa;
            rsp_fault_r <= 1'b0;
            rsp_code_r  <= FLT_NOTPRES;
            rsp_attr_r  <= chk_attr;
            state       <= ST_RESP;
          end
        end
        ST_LEAF_WB: if (mem_ready) begin
          rsp_valid_r <= 1'b1;
          rsp_pa_r    <= pa;
          rsp_fault_r <= 1'b0;
          rsp_code_r  <= FLT_NOTPRES;
          rsp_attr_r  <= chk_attr;
          state       <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) begin
          rsp_valid_r <= 1'b0;
          state       <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign rsp_valid = rsp_valid_r;
  assign rsp_paddr = rsp_pa_r;
  assign rsp_fault = rsp_fault_r;
  assign rsp_fcode = rsp_code_r;
  assign rsp_attr  = rsp_attr_r;

  assign mem_valid = (state == ST_DIR_RQ) || (state == ST_LEAF_RQ) ||
                     (state == ST_DIR_WB) || (state == ST_LEAF_WB);
  assign mem_we    = (state == ST_DIR_WB) || (state == ST_LEAF_WB);
  assign mem_addr  = ((state == ST_DIR_RQ) || (state == ST_DIR_WB)) ? dir_addr : pte_addr;
  assign mem_wdata = (state == ST_DIR_WB) ? (dir_r | A_MASK) : (leaf_r | A_MASK);

  assign va_q       = va_r;
  assign wr_q       = wr_r;
  assign user_q     = user_r;
  assign dir_frame  = dir_r[AW-1:PAGE_BITS];
  assign leaf_frame = leaf_r[AW-1:PAGE_BITS];
  assign dir_flags  = dir_r[DIR_FLAG_W-1:0];
  assign leaf_flags = leaf_r[FLAG_W-1:0];
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walk_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned IDX_BITS  = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_xlate_off,
  input  logic [AW-PAGE_BITS-1:0] cfg_root,
  input  logic                    cfg_wp,
  input  logic                    cfg_pbm,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [AW-1:0]           req_vaddr,
  input  logic                    req_write,
  input  logic                    req_user,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [AW-1:0]           rsp_paddr,
  output logic                    rsp_fault,
  output logic [1:0]              rsp_fcode,
  output logic                    rsp_attr,
  output logic                    mem_valid,
  input  logic                    mem_ready,
  output logic                    mem_we,
  output logic [AW-1:0]           mem_addr,
  output logic [AW-1:0]           mem_wdata,
  input  logic                    mem_rvalid,
  input  logic [AW-1:0]           mem_rdata
);
  localparam int unsigned FRAME_W = AW - PAGE_BITS;

  logic [AW-1:0]         dir_addr, pte_addr, pa, va_q;
  logic                  wr_q, user_q;
  logic [FRAME_W-1:0]    dir_frame, leaf_frame;
  logic [DIR_FLAG_W-1:0] dir_flags;
  logic [FLAG_W-1:0]     leaf_flags;
  logic                  chk_fault, chk_attr, wb_dir, wb_leaf;
  fault_e                chk_code;

  pt_addr_gen #(.AW(AW), .PAGE_BITS(PAGE_BITS), .IDX_BITS(IDX_BITS)) addr_i (
    .root_frame (cfg_root),
    .dir_frame  (dir_frame),
    .leaf_frame (leaf_frame),
    .va         (va_q),
    .dir_addr   (dir_addr),
    .pte_addr   (pte_addr),
    .pa         (pa)
  );

  pt_perm_check perm_i (
    .dir_f    (dir_flags),
    .leaf_f   (leaf_flags),
    .is_write (wr_q),
    .is_user  (user_q),
    .wp_en    (cfg_wp),
    .attr_sel (cfg_pbm),
    .fault    (chk_fault),
    .code     (chk_code),
    .attr     (chk_attr),
    .wb_dir   (wb_dir),
    .wb_leaf  (wb_leaf)
  );

  pt_walk_ctl #(.AW(AW), .PAGE_BITS(PAGE_BITS)) ctl_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_xlate_off (cfg_xlate_off),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .req_write     (req_write),
    .req_user      (req_user),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_paddr     (rsp_paddr),
    .rsp_fault     (rsp_fault),
    .rsp_fcode     (rsp_fcode),
    .rsp_attr      (rsp_attr),
    .mem_valid     (mem_valid),
    .mem_ready     (mem_ready),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_rvalid    (mem_rvalid),
    .mem_rdata     (mem_rdata),
    .dir_addr      (dir_addr),
    .pte_addr      (pte_addr),
    .pa            (pa),
    .chk_fault     (chk_fault),
    .chk_code      (chk_code),
    .chk_attr      (chk_attr),
    .wb_dir        (wb_dir),
    .wb_leaf       (wb_leaf),
    .va_q          (va_q),
    .wr_q          (wr_q),
    .user_q        (user_q),
    .dir_frame     (dir_frame),
    .leaf_frame    (leaf_frame),
    .dir_flags     (dir_flags),
    .leaf_flags    (leaf_flags)
  );
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_xlate_off,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_vaddr,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [AW-1:0] rsp_paddr,
  input logic          rsp_fault,
  input logic [1:0]    rsp_fcode,
  input logic          rsp_attr,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] mem_wdata,
  input logic          mem_rvalid
);
  logic rd_pend;

  always_ff @(posedge clk) begin
    if (!rst_n)                                rd_pend <= 1'b0;
    else if (mem_valid && mem_ready && !mem_we) rd_pend <= 1'b1;
    else if (mem_rvalid)                        rd_pend <= 1'b0;
  end

  // R1: response fields frozen while back-pressured
  a_r1_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)
                                && $stable(rsp_fcode) && $stable(rsp_attr));

  // R1: no new request taken while a response is pending
  a_r1_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R12: memory request frozen until accepted
  a_r12_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we)
                                && $stable(mem_wdata));

  // R12: nothing issued while a read is outstanding
  a_r12_one_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pend |-> !mem_valid);

  // R10: bypass answers at the accepting edge with the request address
  a_r10_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && cfg_xlate_off |=> rsp_valid && !rsp_fault
                                                && rsp_paddr == $past(req_vaddr));

  // R8: every entry write carries the accessed flag
  a_r8_wb_sets_a: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we |-> mem_wdata[5]);
endmodule

bind pt_walker pt_walker_chk #(.AW(AW)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_xlate_off (cfg_xlate_off),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_vaddr     (req_vaddr),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_paddr     (rsp_paddr),
  .rsp_fault     (rsp_fault),
  .rsp_fcode     (rsp_fcode),
  .rsp_attr      (rsp_attr),
  .mem_valid     (mem_valid),
  .mem_ready     (mem_ready),
  .mem_we        (mem_we),
  .mem_addr      (mem_addr),
  .mem_wdata     (mem_wdata),
  .mem_rvalid    (mem_rvalid)
);

// File: tb/pt_walker_tb_top.sv
`timescale 1ns/1ps
module pt_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_xlate_off = 1'b0, cfg_wp = 1'b0, cfg_pbm = 1'b0;
  logic [19:0] cfg_root = 20'h00010;
  logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ready, rsp_valid, rsp_fault, rsp_attr;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_fcode;
  logic        mem_valid, mem_we;
  logic        mem_ready = 1'b1;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #2.5 clk = ~clk;

  pt_walker dut_i (.*);

  typedef struct {
    logic [31:0] pa;
    logic        flt;
    logic [1:0]  code;
    logic        attr;
    int          lat;
    int          nacc;
    int          nwr;
    string       tag;
  } exp_t;

  exp_t        sbq[$];
  logic [31:0] mem_a [logic [31:0]];
  int checks = 0, errors = 0, cyc = 0;
  int wr_cnt = 0, acc_cnt = 0, wr_base = 0, acc_base = 0, acc_cyc = 0;
  int issued = 0, done_cnt = 0, first_cyc = 0;
  bit in_rsp = 0, stall_en = 0, bp_en = 0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem_a.exists(a) ? mem_a[a] : 32'h0;
  endfunction

  function automatic logic [31:0] mkva(input int d, input int t, input int off);
    return {d[9:0], t[9:0], off[11:0]};
  endfunction

  function automatic logic [31:0] mke(input logic [19:0] fr, input logic [11:0] fl);
    return {fr, fl};
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory model: read data returns the cycle after acceptance
  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rvalid <= 1'b0;
    if (rst_n && mem_valid && mem_ready) begin
      acc_cnt = acc_cnt + 1;
      if (mem_we) begin
        mem_a[mem_addr] = mem_wdata;
        wr_cnt = wr_cnt + 1;
      end else begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= rd(mem_addr);
      end
    end
  end

  // back-pressure pattern, changed just after each edge
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_ready = stall_en ? lfsr[1] : 1'b1;
    rsp_ready = bp_en ? lfsr[3] : 1'b1;
  end

  // expected result from the requirements
  function automatic exp_t model(input logic [31:0] va, input logic wr, input logic user,
                                 input bit timed, input string tag);
    exp_t e;
    logic [31:0] de, le;
    logic uok, wok, cd, wt;
    e.pa = '0; e.flt = 1'b0; e.code = 2'd0; e.attr = 1'b0; e.nwr = 0; e.tag = tag;
    if (cfg_xlate_off) begin
      e.pa = va; e.nacc = 0; e.lat = timed ? 0 : -1;
      return e;
    end
    de = rd({cfg_root, va[31:22], 2'b00});
    if (!de[0]) begin
      e.flt = 1'b1; e.code = 2'd0; e.nacc = 1; e.lat = timed ? 2 : -1;
      return e;
    end
    le  = rd({de[31:12], va[21:12], 2'b00});
    uok = de[2] & le[2];
    wok = de[1] & le[1];
    cd  = de[4] | le[4];
    wt  = de[3] | le[3];
    e.flt = 1'b1;
    if (!le[0])                               e.code = 2'd0;
    else if (user && !uok)                    e.code = 2'd1;
    else if (wr && !wok && (user || cfg_wp))  e.code = 2'd2;
    else if (wr && !le[6])                    e.code = 2'd3;
    else                                      e.flt  = 1'b0;
    if (!e.flt) begin
      e.pa   = {le[31:12], va[11:0]};
      e.attr = cfg_pbm ? wt : cd;
      e.nwr  = (de[5] ? 0 : 1) + (le[5] ? 0 : 1);
    end
    e.nacc = 2 + e.nwr;
    e.lat  = timed ? 5 + e.nwr : -1;
    return e;
  endfunction

  task automatic walk(input logic [31:0] va, input logic wr, input logic user, input string tag);
    exp_t e;
    e = model(va, wr, user, !stall_en, tag);
    sbq.push_back(e);
    @(posedge clk); #1;
    req_valid = 1'b1; req_vaddr = va; req_write = wr; req_user = user;
    do @(negedge clk); while (!req_ready);
    acc_cyc  = cyc + 1;
    wr_base  = wr_cnt;
    acc_base = acc_cnt;
    issued++;
    @(posedge clk); #1;
    req_valid = 1'b0;
    wait (done_cnt == issued);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rsp_valid && !in_rsp) begin
      in_rsp = 1;
      first_cyc = cyc;
    end
    if (rsp_valid && rsp_ready) begin
      if (sbq.size() == 0) begin
        checks++; errors++;
        $display("FAIL R1 unexpected response: actual=%h expected=none", rsp_paddr);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        chk(e.tag, "paddr", rsp_paddr, e.pa);
        chk(e.tag, "fault/code/attr", {28'h0, rsp_fault, rsp_fcode, rsp_attr},
            {28'h0, e.flt, e.code, e.attr});
        chk(e.tag, "memory accesses", acc_cnt - acc_base, e.nacc);
        chk(e.tag, "entry writes", wr_cnt - wr_base, e.nwr);
        if (e.lat >= 0) chk({e.tag, " R11"}, "latency", first_cyc - acc_cyc, e.lat);
      end
      in_rsp = 0;
      done_cnt++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    // tables: directory at frame 0x00010, leaves at 0x20/0x21/0x22
    mem_a[{20'h00010, 10'd1, 2'b0}] = mke(20'h00020, 12'h027);
    mem_a[{20'h00010, 10'd2, 2'b0}] = mke(20'h00021, 12'h007);
    mem_a[{20'h00010, 10'd3, 2'b0}] = mke(20'h00020, 12'h026);
    mem_a[{20'h00010, 10'd4, 2'b0}] = mke(20'h00020, 12'h023);
    mem_a[{20'h00010, 10'd5, 2'b0}] = mke(20'h00022, 12'h037);
    mem_a[{20'h00010, 10'd6, 2'b0}] = mke(20'h00021, 12'h007);
    mem_a[{20'h00010, 10'd7, 2'b0}] = mke(20'h00021, 12'h007);
    mem_a[{20'h00020, 10'd1, 2'b0}] = mke(20'hABCDE, 12'h067);
    mem_a[{20'h00020, 10'd2, 2'b0}] = mke(20'h12345, 12'h065);
    mem_a[{20'h00020, 10'd3, 2'b0}] = mke(20'h55555, 12'h027);
    mem_a[{20'h00020, 10'd4, 2'b0}] = mke(20'h99999, 12'h066);
    mem_a[{20'h00020, 10'd5, 2'b0}] = mke(20'h0F0F0, 12'h025);
    mem_a[{20'h00020, 10'd6, 2'b0}] = mke(20'h13579, 12'h06F);
    mem_a[{20'h00021, 10'd1, 2'b0}] = mke(20'h33333, 12'h047);
    mem_a[{20'h00021, 10'd2, 2'b0}] = mke(20'h44444, 12'h063);
    mem_a[{20'h00021, 10'd3, 2'b0}] = mke(20'h77700, 12'h047);
    mem_a[{20'h00022, 10'd1, 2'b0}] = mke(20'h66666, 12'h06F);
    mem_a[{20'h00022, 10'd2, 2'b0}] = mke(20'h77777, 12'h067);

    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset req_ready", {31'h0, req_ready}, 32'h1);
    chk("R1", "reset rsp_valid", {31'h0, rsp_valid}, 32'h0);
    chk("R12", "reset mem_valid", {31'h0, mem_valid}, 32'h0);

    walk(mkva(1, 1, 12'h123), 0, 1, "R2 user read");
    walk(mkva(1, 1, 12'hFFF), 1, 0, "R2 sup write");
    cfg_xlate_off = 1'b1;
    walk(32'hDEADBEEF, 1, 1, "R10 bypass");
    cfg_xlate_off = 1'b0;

    walk(mkva(2, 1, 12'h7FC), 0, 0, "R8 both A clear");
    chk("R8", "dir word", rd({20'h00010, 10'd2, 2'b0}), 32'h00021027);
    chk("R8", "leaf word", rd({20'h00021, 10'd1, 2'b0}), 32'h33333067);
    walk(mkva(2, 1, 12'h7FC), 0, 0, "R8 A now set");

    walk(mkva(3, 0, 0), 0, 0, "R3 dir absent");
    walk(mkva(1, 4, 12'h010), 0, 0, "R3 leaf absent");

    walk(mkva(4, 1, 0), 0, 1, "R4 dir user clear");
    walk(mkva(4, 1, 0), 1, 0, "R4 supervisor ok");

    walk(mkva(1, 2, 12'h044), 1, 1, "R5 user write ro");
    walk(mkva(1, 2, 12'h044), 1, 0, "R5 sup write wp0");
    cfg_wp = 1'b1;
    walk(mkva(1, 2, 12'h044), 1, 0, "R5 sup write wp1");
    cfg_wp = 1'b0;

    walk(mkva(1, 3, 12'h008), 1, 0, "R6 dirty trap");
    walk(mkva(1, 3, 12'h008), 0, 1, "R6 read clean");

    walk(mkva(1, 5, 0), 1, 1, "R7 wprot over dirty");
    walk(mkva(4, 5, 0), 1, 1, "R7 priv over wprot");
    walk(mkva(1, 4, 0), 1, 1, "R7 absent first");

    walk(mkva(6, 2, 0), 0, 1, "R8 fault no write");
    chk("R8", "dir word untouched", rd({20'h00010, 10'd6, 2'b0}), 32'h00021007);

    walk(mkva(5, 1, 0), 0, 0, "R9 pbm0 cd+wt");
    walk(mkva(5, 2, 0), 0, 0, "R9 pbm0 cd");
    walk(mkva(1, 6, 0), 0, 0, "R9 pbm0 wt");
    cfg_pbm = 1'b1;
    walk(mkva(5, 1, 0), 0, 0, "R9 pbm1 cd+wt");
    walk(mkva(5, 2, 0), 0, 0, "R9 pbm1 cd");
    walk(mkva(1, 6, 0), 0, 0, "R9 pbm1 wt");
    cfg_pbm = 1'b0;

    stall_en = 1; bp_en = 1;
    walk(mkva(7, 3, 12'h3A0), 1, 0, "R12 stalled A writes");
    chk("R12", "dir word", rd({20'h00010, 10'd7, 2'b0}), 32'h00021027);
    chk("R12", "leaf word", rd({20'h00021, 10'd3, 2'b0}), 32'h77700067);
    walk(mkva(1, 1, 12'h001), 0, 1, "R1 stalled read");
    walk(mkva(3, 0, 0), 1, 1, "R1 stalled absent");
    walk(mkva(1, 3, 0), 1, 1, "R1 stalled dirty");
    cfg_xlate_off = 1'b1;
    walk(32'h0000_1234, 0, 0, "R10 stalled bypass");
    cfg_xlate_off = 1'b0;
    stall_en = 0; bp_en = 0;
    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule